// File: doc/BRIEF.md
# Latched Hex Seven-Segment Decoder

This block turns a 4-bit binary value into the seven active-high segment drives of a common-cathode display. All sixteen codes give a visible glyph: the digits 0 to 9 and the letters A, b, C, d, E, F. A transparent input latch sits in front of the decoder. While the active-low enable `hold_n` is low, the display follows the live input. Once it is raised, the value present at the last clock edge with the enable low is held. The held value stays on the display whatever the inputs do.

Several instances can be chained to suppress leading or trailing zeros in a multi-digit number. An active-low blank request `zblank_in_n` blanks the digit only when the displayed value is zero. In that case `zblank_out_n` drops low, so the next stage in the chain can blank its own zero. A separate active-low `kill_n` input blanks the whole digit from outside and overrides every other input, for example to modulate brightness.

The latch is modelled as a register that samples the input on every rising clock edge while `hold_n` is low. A multiplexer gives the same-cycle transparency.

Top module: `hexseg_latch_dec`

## Requirements
- R1: After reset, with `hold_n` high, `zblank_in_n` high and `kill_n` high, the held value is zero: `seg` = 7'h3F and `zblank_out_n` = 1.
- R2: `seg` uses bit order {g,f,e,d,c,b,a}, active high. The digits 0 to 9 map to 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).
- R3: The codes 10 to 15 map to the glyphs A, b, C, d, E, F, which are 77, 7C, 39, 5E, 79, 71 (hex).
- R4: While `hold_n` is low, `seg` follows `code_in` in the same cycle, with no clock edge needed.
- R5: While `hold_n` is high, `seg` shows the `code_in` value sampled at the last rising `clk` edge with `hold_n` low. Changes on `code_in` have no effect.
- R6: When the displayed value is zero and `zblank_in_n` is low, `seg` = 0 and `zblank_out_n` = 0.
- R7: When the displayed value is non-zero, `zblank_in_n` has no effect: the glyph is shown and `zblank_out_n` = 1.
- R8: When `kill_n` is low, `seg` = 0 whatever the data, latch and blank inputs are. `zblank_out_n` still reports only the zero-blank condition of R6.
- R9: When `zblank_in_n` is high, `zblank_out_n` is 1 even for a displayed zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the latch emulation |
| rst_n | input | 1 | Asynchronous active-low reset; clears the held value |
| hold_n | input | 1 | Active-low latch enable: low = transparent, high = hold |
| code_in | input | 4 | Binary code to display |
| zblank_in_n | input | 1 | Active-low ripple blank request for a zero |
| kill_n | input | 1 | Active-low forced blank of all segments |
| seg | output | 7 | Segment drives {g,f,e,d,c,b,a}, active high |
| zblank_out_n | output | 1 | Active-low: low when this digit was blanked as a zero |

## Verification
The hardest case to reach is a stored zero being blanked while the live input carries a non-zero code. It matters because blanking must look at the held value and not at the pins. The bench captures zero with the enable low, raises the enable, and then puts a non-zero code on the input before asserting the blank request. It also runs the reverse case: a non-zero value is held and a zero is driven live. Together these show that blanking and display both follow the held value.

// File: rtl/hexseg_pkg.sv
package hexseg_pkg;
  localparam int CODE_W = 4;
  localparam int SEG_W  = 7;
  localparam int NUM_CODES = 1 << CODE_W;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [SEG_W-1:0]  seg_t;

  // Segment pattern, bit order {g,f,e,d,c,b,a}, active high.
  function automatic seg_t glyph_of(input code_t c);
    seg_t s;
    case (c)
      4'h0: s = 7'h3F;
      4'h1: s = 7'h06;
      4'h2: s = 7'h5B;
      4'h3: s = 7'h4F;
      4'h4: s = 7'h66;
      4'h5: s = 7'h6D;
      4'h6: s = 7'h7D;
      4'h7: s = 7'h07;
      4'h8: s = 7'h7F;
      4'h9: s = 7'h6F;
      4'hA: s = 7'h77;
      4'hB: s = 7'h7C;
      4'hC: s = 7'h39;
      4'hD: s = 7'h5E;
      4'hE: s = 7'h79;
      default: s = 7'h71;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/hexseg_hold.sv
module hexseg_hold
  import hexseg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  hold_n,
  input  code_t code_in,
  output code_t held,
  output code_t shown
);
  // Register loads on every edge while the enable is low.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held <= '0;
    else if (!hold_n) held <= code_in;
  end

  // Transparency: the live input passes straight through while the enable is low.
  assign shown = hold_n ? held : code_in;
endmodule

// File: rtl/hexseg_glyph.sv
module hexseg_glyph
  import hexseg_pkg::*;
(
  input  code_t value,
  output seg_t  pattern
);
  assign pattern = glyph_of(value);
endmodule

// File: rtl/hexseg_blank.sv
module hexseg_blank
  import hexseg_pkg::*;
(
  input  code_t value,
  input  seg_t  pattern,
  input  logic  zblank_in_n,
  input  logic  kill_n,
  output seg_t  seg,
  output logic  zero_hit,
  output logic  zblank_out_n
);
  logic is_zero;
  assign is_zero      = (value == '0);
  assign zero_hit     = is_zero && !zblank_in_n;
  assign zblank_out_n = !zero_hit;
  assign seg          = (!kill_n || zero_hit) ? '0 : pattern;
endmodule

// File: rtl/hexseg_latch_dec.sv
module hexseg_latch_dec
  import hexseg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_n,
  input  logic [CODE_W-1:0] code_in,
  input  logic             zblank_in_n,
  input  logic             kill_n,
  output logic [SEG_W-1:0] seg,
  output logic             zblank_out_n
);
  code_t held_q;
  code_t shown_w;
  seg_t  raw_pattern;
  logic  zero_hit;

  hexseg_hold u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold_n  (hold_n),
    .code_in (code_in),
    .held    (held_q),
    .shown   (shown_w)
  );

  hexseg_glyph u_glyph (
    .value   (shown_w),
    .pattern (raw_pattern)
  );

  hexseg_blank u_blank (
    .value        (shown_w),
    .pattern      (raw_pattern),
    .zblank_in_n  (zblank_in_n),
    .kill_n       (kill_n),
    .seg          (seg),
    .zero_hit     (zero_hit),
    .zblank_out_n (zblank_out_n)
  );
endmodule

// File: rtl/hexseg_latch_dec_chk.sv
module hexseg_latch_dec_chk
  import hexseg_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        hold_n,
  input logic [3:0]  code_in,
  input logic        zblank_in_n,
  input logic        kill_n,
  input logic [6:0]  seg,
  input logic        zblank_out_n,
  input logic [3:0]  held_q
);
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_n && $past(hold_n) && $stable(zblank_in_n) && $stable(kill_n)) |-> $stable(seg)); // R5

  AST_CAPTURE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(hold_n) && hold_n) |-> (held_q == $past(code_in))); // R5

  AST_KILL_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!kill_n) |-> (seg == '0)); // R8

  AST_ZERO_OUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!zblank_out_n) |-> (!zblank_in_n && seg == '0)); // R6

  AST_RBI_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    zblank_in_n |-> zblank_out_n); // R9

  AST_TRANSPARENT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_n && kill_n && code_in != '0) |-> (seg != '0 && zblank_out_n)); // R4
endmodule

bind hexseg_latch_dec hexseg_latch_dec_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hold_n       (hold_n),
  .code_in      (code_in),
  .zblank_in_n  (zblank_in_n),
  .kill_n       (kill_n),
  .seg          (seg),
  .zblank_out_n (zblank_out_n),
  .held_q       (held_q)
);

// File: tb/hexseg_latch_dec_bench.sv
`timescale 1ns/1ps
module hexseg_latch_dec_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hold_n = 1'b1;
  logic [3:0] code_in = 4'h0;
  logic       zblank_in_n = 1'b1;
  logic       kill_n = 1'b1;
  logic [6:0] seg;
  logic       zblank_out_n;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  hexseg_latch_dec u_hexseg_latch_dec (
    .clk(clk), .rst_n(rst_n), .hold_n(hold_n), .code_in(code_in),
    .zblank_in_n(zblank_in_n), .kill_n(kill_n),
    .seg(seg), .zblank_out_n(zblank_out_n)
  );

  function automatic logic [6:0] expect_glyph(input int v);
    logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                          7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
    return t[v];
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Inputs change just after a rising edge; outputs are sampled at the falling edge.
  task automatic step;
    @(posedge clk); #1;
  endtask

  task automatic settle;
    @(negedge clk);
  endtask

  task automatic t_reset;
    settle;
    check("R1 seg", {1'b0, seg}, 8'h3F);
    check("R1 zblank_out_n", {7'b0, zblank_out_n}, 8'h01);
  endtask

  task automatic t_digits;
    hold_n = 1'b0;
    for (int v = 0; v < 10; v++) begin
      code_in = v[3:0]; settle;
      check("R2 digit", {1'b0, seg}, {1'b0, expect_glyph(v)});
      step;
    end
  endtask

  task automatic t_letters;
    hold_n = 1'b0;
    for (int v = 10; v < 16; v++) begin
      code_in = v[3:0]; settle;
      check("R3 letter", {1'b0, seg}, {1'b0, expect_glyph(v)});
      step;
    end
  endtask

  task automatic t_transparent;
    step; hold_n = 1'b0; code_in = 4'h5;
    #0.5;
    check("R4 same cycle", {1'b0, seg}, 8'h6D);
    code_in = 4'hC; #0.5;
    check("R4 follows", {1'b0, seg}, 8'h39);
  endtask

  task automatic t_hold;
    step; hold_n = 1'b0; code_in = 4'h7;
    step; hold_n = 1'b1; code_in = 4'h2;
    settle; check("R5 held", {1'b0, seg}, 8'h07);
    step; code_in = 4'hF; settle;
    check("R5 ignore input", {1'b0, seg}, 8'h07);
    step; hold_n = 1'b0; settle;
    check("R5 reopen", {1'b0, seg}, 8'h71);
  endtask

  task automatic t_stored_zero_blank;
    step; hold_n = 1'b0; code_in = 4'h0;
    step; hold_n = 1'b1; code_in = 4'h9; zblank_in_n = 1'b0;
    settle;
    check("R6 seg", {1'b0, seg}, 8'h00);
    check("R6 zblank_out_n", {7'b0, zblank_out_n}, 8'h00);
    step; zblank_in_n = 1'b1; settle;
    check("R9 zero shown", {1'b0, seg}, 8'h3F);
    check("R9 zblank_out_n", {7'b0, zblank_out_n}, 8'h01);
  endtask

  task automatic t_nonzero_rbi;
    step; hold_n = 1'b0; code_in = 4'h4;
    step; hold_n = 1'b1; code_in = 4'h0; zblank_in_n = 1'b0;
    settle;
    check("R7 seg", {1'b0, seg}, 8'h66);
    check("R7 zblank_out_n", {7'b0, zblank_out_n}, 8'h01);
    step; zblank_in_n = 1'b1;
  endtask

  task automatic t_kill;
    step; hold_n = 1'b0; code_in = 4'h8; kill_n = 1'b0; settle;
    check("R8 kill nonzero", {1'b0, seg}, 8'h00);
    check("R8 zblank_out_n", {7'b0, zblank_out_n}, 8'h01);
    step; code_in = 4'h0; zblank_in_n = 1'b0; settle;
    check("R8 kill zero seg", {1'b0, seg}, 8'h00);
    check("R8 kill zero out", {7'b0, zblank_out_n}, 8'h00);
    step; kill_n = 1'b1; zblank_in_n = 1'b1; code_in = 4'hA; settle;
    check("R8 release", {1'b0, seg}, 8'h77);
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset;
    t_digits;
    t_letters;
    t_transparent;
    t_hold;
    t_stored_zero_blank;
    t_nonzero_rbi;
    t_kill;
    step;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule